// File: doc/BRIEF.md
# Pulse-Width and Pulse-Count Duty Generator with Shadowed Compare

This block drives one output pin with a programmable duty cycle over a fixed period of `2**CNT_W` clock cycles. A free-running period counter is compared with the active duty value. In pulse-width mode the ON cycles form one contiguous pulse at the start of each period. In pulse-count mode the same number of ON cycles is spread over the period as isolated single-cycle pulses. This is done by comparing the duty value with the bit-reversed counter.

The duty value lives in a compare register. Software can load it directly, or a hardware trigger can copy a preloaded shadow value into it. The trigger input passes through a two-flop synchroniser and then a two-state level tracker with the states `TRG_LOW` and `TRG_HIGH`. In `TRG_LOW` a high input is a rising edge and moves the tracker to `TRG_HIGH`. In `TRG_HIGH` a low input is a falling edge and moves it back to `TRG_LOW`. In all other cases the state is held. Software selects which of these edges count as events, or selects level mode, in which every cycle with a high synchronised input is an event. Each event sets a sticky service request flag and, when enabled, gives a one-cycle interrupt pulse. A compare value reaches the output only at the next period boundary.

Top module: `duty_mod_gen`

## Requirements
- R1: After reset, `pwm_out`, `srq_flag` and `irq` are 0, and `cmp_value` is 0.
- R2: With `pcm_mode`=0 and an active duty D below the period, `pwm_out` is high for exactly D consecutive cycles in each period of `2**CNT_W` cycles, and low for the rest.
- R3: With `pcm_mode`=1 and an active duty D of at most half the period, `pwm_out` is high for exactly D cycles per period. No two high cycles are adjacent, so the longest high run is 1.
- R4: An active duty of 0 holds `pwm_out` low. An active duty equal to or above the period holds it high. Both hold in either mode.
- R5: A software write (`cmp_wr_en`) shows on `cmp_value` after the next clock edge. If a trigger event falls on the same edge, the software write wins.
- R6: A new compare value does not change `pwm_out` within the current period. It becomes the active duty at the start of the next period.
- R7: A trigger event copies the shadow register into the compare register and sets `srq_flag`. A change on `trig_in` takes effect on the third rising clock edge after it, because of the two synchroniser flops.
- R8: `irq` pulses high for one cycle per trigger event when `irq_en`=1. It stays low when `irq_en`=0.
- R9: With `trig_level`=1, every cycle in which the synchronised input is high is an event. A held-high input therefore gives one `irq` pulse per cycle.
- R10: With `trig_level`=0, a rising edge is an event only if `rise_en`=1, and a falling edge is an event only if `fall_en`=1. With both set, both edges are events.
- R11: A one-cycle `flag_clr` pulse clears `srq_flag`. If an event falls on the same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcm_mode | input | 1 | 0 = contiguous pulse, 1 = spread single-cycle pulses |
| cmp_wr_en | input | 1 | Software load strobe for the compare register |
| cmp_wr_data | input | VAL_W | Software compare value |
| shd_wr_en | input | 1 | Load strobe for the shadow register |
| shd_wr_data | input | VAL_W | Next duty value to preload |
| trig_in | input | 1 | Asynchronous hardware trigger |
| trig_level | input | 1 | 1 = level sensitive (high active), 0 = edge sensitive |
| rise_en | input | 1 | Rising edges are events (edge mode) |
| fall_en | input | 1 | Falling edges are events (edge mode) |
| irq_en | input | 1 | Interrupt request enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the service flag |
| pwm_out | output | 1 | Modulated output pin |
| cmp_value | output | VAL_W | Current compare register contents |
| srq_flag | output | 1 | Sticky service request flag |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest case to reach is a compare update that arrives in the middle of a period. The counter cannot be seen at the ports, so the bench first finds its phase. It loads a duty of 1 in pulse-width mode and waits for the single high cycle, which marks count 0. It then writes a new value ten cycles later and checks that the rest of the period stays low and that the next period carries the new pulse. The set-and-clear collision of the flag is reached by holding the trigger high in level mode, so that every edge carries an event.

// File: rtl/dmg_pkg.sv
package dmg_pkg;
    typedef enum logic {
        TRG_LOW  = 1'b0,
        TRG_HIGH = 1'b1
    } trg_state_t;
endpackage

// File: rtl/dmg_sync.sv
module dmg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/dmg_trig_fsm.sv
module dmg_trig_fsm
    import dmg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic level_mode,
    input  logic rise_en,
    input  logic fall_en,
    output logic event_o
);
    trg_state_t state_q, state_d;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRG_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        fall    = 1'b0;
        unique case (state_q)
            TRG_LOW: begin
                if (lvl) begin
                    state_d = TRG_HIGH;
                    rise    = 1'b1;
                end
            end
            TRG_HIGH: begin
                if (!lvl) begin
                    state_d = TRG_LOW;
                    fall    = 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        if (level_mode) event_o = lvl;
        else            event_o = (rise & rise_en) | (fall & fall_en);
    end

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && !level_mode) |-> (lvl != $past(lvl)))
        else $error("edge event without input change"); // R10
endmodule

// File: rtl/dmg_duty_core.sv
module dmg_duty_core #(
    parameter int CNT_W = 7,
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pcm_mode,
    input  logic [VAL_W-1:0] cmp_val,
    output logic             out_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [VAL_W-1:0] HALF    = VAL_W'(1) << (CNT_W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_rev;
    logic [VAL_W-1:0] act_q;
    logic [CNT_W-1:0] sel;

    for (genvar i = 0; i < CNT_W; i++) begin : g_rev
        assign cnt_rev[i] = cnt_q[CNT_W-1-i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_MAX) act_q <= cmp_val;
        end
    end

    assign sel   = pcm_mode ? cnt_rev : cnt_q;
    assign out_o = {{(VAL_W-CNT_W){1'b0}}, sel} < act_q;

    AST_ACT_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q != $past(act_q)) |-> ($past(cnt_q) == CNT_MAX))
        else $error("duty changed inside a period"); // R6

    AST_PCM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_mode && $past(pcm_mode) && act_q == $past(act_q) && act_q <= HALF && $past(out_o))
        |-> !out_o)
        else $error("adjacent high cycles in pulse-count mode"); // R3
endmodule

// File: rtl/duty_mod_gen.sv
module duty_mod_gen #(
    parameter int CNT_W = 7,
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pcm_mode,
    input  logic             cmp_wr_en,
    input  logic [VAL_W-1:0] cmp_wr_data,
    input  logic             shd_wr_en,
    input  logic [VAL_W-1:0] shd_wr_data,
    input  logic             trig_in,
    input  logic             trig_level,
    input  logic             rise_en,
    input  logic             fall_en,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic             pwm_out,
    output logic [VAL_W-1:0] cmp_value,
    output logic             srq_flag,
    output logic             irq
);
    logic [VAL_W-1:0] cmp_q, shd_q;
    logic             flag_q, irq_q;
    logic             trig_sync, trig_evt;

    dmg_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(trig_in), .sync_out(trig_sync)
    );

    dmg_trig_fsm u_trig (
        .clk(clk), .rst_n(rst_n), .lvl(trig_sync), .level_mode(trig_level),
        .rise_en(rise_en), .fall_en(fall_en), .event_o(trig_evt)
    );

    dmg_duty_core #(.CNT_W(CNT_W), .VAL_W(VAL_W)) u_core (
        .clk(clk), .rst_n(rst_n), .pcm_mode(pcm_mode), .cmp_val(cmp_q), .out_o(pwm_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            shd_q  <= '0;
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (shd_wr_en)     shd_q <= shd_wr_data;
            if (cmp_wr_en)     cmp_q <= cmp_wr_data;
            else if (trig_evt) cmp_q <= shd_q;
            if (trig_evt)      flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
            irq_q <= trig_evt & irq_en;
        end
    end

    assign cmp_value = cmp_q;
    assign srq_flag  = flag_q;
    assign irq       = irq_q;

    AST_TRIG_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(trig_evt) && !$past(cmp_wr_en)) |-> (cmp_q == $past(shd_q)))
        else $error("shadow not transferred"); // R7

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(trig_evt) |-> srq_flag)
        else $error("flag lost on event"); // R11

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(irq_en) && $past(trig_evt)))
        else $error("irq without enabled event"); // R8
endmodule

// File: tb/sim_duty_mod_gen.sv
`timescale 1ns/1ps
module sim_duty_mod_gen;
    localparam int CNT_W = 7;
    localparam int VAL_W = 16;
    localparam int PER   = 1 << CNT_W;

    logic clk = 0, rst_n = 0;
    logic pcm_mode = 0, cmp_wr_en = 0, shd_wr_en = 0;
    logic [VAL_W-1:0] cmp_wr_data = 0, shd_wr_data = 0;
    logic trig_in = 0, trig_level = 0, rise_en = 0, fall_en = 0, irq_en = 0, flag_clr = 0;
    logic pwm_out, srq_flag, irq;
    logic [VAL_W-1:0] cmp_value;
    int checks = 0, errors = 0, cyc = 0;

    always #4 clk = ~clk;

    duty_mod_gen #(.CNT_W(CNT_W), .VAL_W(VAL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pcm_mode(pcm_mode), .cmp_wr_en(cmp_wr_en),
        .cmp_wr_data(cmp_wr_data), .shd_wr_en(shd_wr_en), .shd_wr_data(shd_wr_data),
        .trig_in(trig_in), .trig_level(trig_level), .rise_en(rise_en), .fall_en(fall_en),
        .irq_en(irq_en), .flag_clr(flag_clr), .pwm_out(pwm_out), .cmp_value(cmp_value),
        .srq_flag(srq_flag), .irq(irq)
    );

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc > 150000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sw_write(int v);
        cmp_wr_data = VAL_W'(v); cmp_wr_en = 1; tick(); cmp_wr_en = 0;
    endtask

    task automatic shd_write(int v);
        shd_wr_data = VAL_W'(v); shd_wr_en = 1; tick(); shd_wr_en = 0;
    endtask

    task automatic clr_flag();
        flag_clr = 1; tick(); flag_clr = 0;
    endtask

    task automatic measure(int n, output int on_cnt, output int max_run);
        int run = 0;
        on_cnt = 0; max_run = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (pwm_out) begin
                on_cnt++; run++;
                if (run > max_run) max_run = run;
            end else run = 0;
        end
    endtask

    task automatic count_irq(int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (irq) cnt++;
        end
    endtask

    task automatic t_reset();
        tick(3);
        chk("R1 pwm_out", pwm_out, 0);
        chk("R1 srq_flag", srq_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 cmp_value", cmp_value, 0);
        rst_n = 1;
        tick();
    endtask

    task automatic t_pwm(int d);
        int on_c, run;
        pcm_mode = 0; sw_write(d); tick(2 * PER);
        measure(2 * PER, on_c, run);
        chk("R2 on count", on_c, 2 * d);
        chk("R2 pulse length", run, d);
    endtask

    task automatic t_pcm(int d);
        int on_c, run;
        pcm_mode = 1; sw_write(d); tick(2 * PER);
        measure(2 * PER, on_c, run);
        chk("R3 on count", on_c, 2 * d);
        chk("R3 longest run", run, 1);
    endtask

    task automatic t_extremes();
        int on_c, run;
        for (int m = 0; m < 2; m++) begin
            pcm_mode = m[0];
            sw_write(0); tick(2 * PER);
            measure(PER, on_c, run);
            chk("R4 zero duty low", on_c, 0);
            sw_write(200); tick(2 * PER);
            measure(PER, on_c, run);
            chk("R4 over-period duty high", on_c, PER);
            sw_write(PER); tick(2 * PER);
            measure(PER, on_c, run);
            chk("R4 full-period duty high", on_c, PER);
        end
    endtask

    task automatic t_boundary();
        int bad = 0, mism = 0, guard = 0;
        pcm_mode = 0; sw_write(1); tick(2 * PER);
        while (!pwm_out && guard < 3 * PER) begin tick(); guard++; end
        chk("R6 phase found", pwm_out, 1);
        tick(10);
        cmp_wr_data = 64; cmp_wr_en = 1;
        tick(); cmp_wr_en = 0;
        chk("R5 cmp_value after write", cmp_value, 64);
        for (int c = 11; c < PER; c++) begin
            if (c > 11) tick();
            if (pwm_out) bad++;
        end
        chk("R6 rest of period unchanged", bad, 0);
        for (int c = 0; c < PER; c++) begin
            tick();
            if (pwm_out != (c < 64)) mism++;
        end
        chk("R6 next period uses new duty", mism, 0);
    endtask

    task automatic t_edge();
        int n;
        pcm_mode = 0; trig_level = 0; rise_en = 1; fall_en = 0; irq_en = 1;
        sw_write(5); shd_write(40);
        trig_in = 1;
        tick(); chk("R7 no effect after 1 edge", srq_flag, 0);
        tick(); chk("R7 no effect after 2 edges", srq_flag, 0);
        tick(); chk("R7 flag after 3 edges", srq_flag, 1);
        chk("R7 shadow copied", cmp_value, 40);
        chk("R8 irq pulse present", irq, 1);
        tick(); chk("R8 irq one cycle", irq, 0);
        clr_flag(); chk("R11 flag cleared", srq_flag, 0);
        shd_write(50);
        trig_in = 0; tick(6);
        chk("R10 fall ignored flag", srq_flag, 0);
        chk("R10 fall ignored cmp", cmp_value, 40);
        rise_en = 0; fall_en = 1; irq_en = 0;
        trig_in = 1; tick(6);
        chk("R10 rise ignored", srq_flag, 0);
        trig_in = 0; count_irq(6, n);
        chk("R10 fall event flag", srq_flag, 1);
        chk("R10 fall event cmp", cmp_value, 50);
        chk("R8 irq masked", n, 0);
        rise_en = 1; clr_flag();
        trig_in = 1; tick(6);
        chk("R10 both: rise", srq_flag, 1);
        clr_flag(); trig_in = 0; tick(6);
        chk("R10 both: fall", srq_flag, 1);
        clr_flag();
    endtask

    task automatic t_level();
        int n;
        trig_level = 1; rise_en = 0; fall_en = 0; irq_en = 1;
        shd_write(50);
        trig_in = 1; tick(4);
        count_irq(5, n);
        chk("R9 irq every cycle", n, 5);
        chk("R9 level copy", cmp_value, 50);
        clr_flag();
        chk("R11 event beats clear", srq_flag, 1);
        sw_write(77);
        chk("R5 sw write wins over event", cmp_value, 77);
        tick();
        chk("R9 next event copies again", cmp_value, 50);
        trig_in = 0; tick(5);
        clr_flag();
        chk("R11 clear with no event", srq_flag, 0);
        count_irq(4, n);
        chk("R9 low input no irq", n, 0);
    endtask

    initial begin
        t_reset();
        t_pwm(8);
        t_pwm(100);
        t_pcm(8);
        t_pcm(37);
        t_extremes();
        t_boundary();
        t_edge();
        t_level();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule